// File: doc/BRIEF.md
# CAN Controller Interrupt Flag Register

This block is the interrupt status byte of a CAN controller. It sits at one address of the controller's CPU register window. It watches level and pulse signals from the rest of the controller and turns them into sticky flag bits. Those signals are the sleep state, new-message notification, the error and bus status bits, the transmit-buffer access level, and the receive-buffer overrun condition. Four of the five sources are gated by enable inputs, which come from an enable register outside this block. While any flag is set, a single interrupt request line to the CPU is held high.

The register is read-only. When the CPU reads it, the read returns the current flags and all flags clear at the following clock edge. If an event arrives in the same cycle as that clearing read, the event still gets recorded.

Top module: `can_irq_status`

## Requirements
- R1: A synchronous active-high reset clears all flags, the interrupt request and the edge-detector history. After reset, a read returns 0x00 and `irq_o` is low.
- R2: When `cpu_rd` is high and `cpu_addr` equals `REG_ADDR` (default 3), `cpu_rdata` returns the flags combinationally. The bit positions are: bit 0 receive, bit 1 transmit, bit 2 error, bit 3 overrun, bit 4 wake-up. Bits 7..5 read 0. When the register is not addressed, `cpu_rdata` is 0.
- R3: A read of `REG_ADDR` clears all flags at the next clock edge. A read of any other address clears nothing.
- R4: When a set condition occurs in the same cycle as a clearing read, the flag is set after that edge.
- R5: `irq_o` is high in exactly the cycles in which at least one flag is set. It changes at the same edge as the flags.
- R6: The receive flag sets when `rx_msg_new` and `en_rx` are both high. If `en_rx` is low, the flag does not set.
- R7: The transmit flag sets on a low-to-high transition of `tx_buf_free`, but only while `en_tx` is high. A level held high, or a falling edge, does not set it.
- R8: The error flag sets when `err_status` or `bus_status` changes value in either direction, but only while `en_err` is high.
- R9: The overrun flag sets only when `en_ovr`, `rxbuf_both_full` and `rx_accept_start` are all high in the same cycle.
- R10: The wake-up flag sets on a high-to-low transition of `sleep_mode`. No enable gates it.
- R11: A set flag stays set until a clearing read or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_addr | input | ADDR_W | CPU register address |
| cpu_rdata | output | DATA_W | Read data; zero when this register is not addressed |
| irq_o | output | 1 | Interrupt request to the CPU |
| en_rx | input | 1 | Receive interrupt enable |
| en_tx | input | 1 | Transmit interrupt enable |
| en_err | input | 1 | Error interrupt enable |
| en_ovr | input | 1 | Overrun interrupt enable |
| rx_msg_new | input | 1 | Pulse: a new message is available in the receive buffer |
| tx_buf_free | input | 1 | Level: transmit buffer released to the CPU |
| err_status | input | 1 | Level: error status bit |
| bus_status | input | 1 | Level: bus status bit |
| sleep_mode | input | 1 | Level: controller is in sleep mode |
| rxbuf_both_full | input | 1 | Level: both receive buffers hold a message |
| rx_accept_start | input | 1 | Pulse: first byte of an accepted message needs storing |

## Verification
The hardest situation to reach is a set event landing in the same cycle as a clearing read. The stimulus reaches it by first setting the error flag. In the next row it drops `err_status` while reading the register, and a second read then confirms the flag survived. The bench also holds `tx_buf_free` high across two reads, to show that a steady level does not re-arm the transmit flag. It toggles `bus_status` with the error enable off and then back with it on, so that both directions of a change are covered.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
    localparam int NUM_SRC = 5;
    localparam int B_RX    = 0;
    localparam int B_TX    = 1;
    localparam int B_ERR   = 2;
    localparam int B_OVR   = 3;
    localparam int B_WAKE  = 4;

    typedef enum logic [1:0] {EDGE_RISE, EDGE_FALL, EDGE_ANY} edge_mode_e;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef struct packed {
        src_vec_t flags;
        logic     irq;
    } flag_state_t;
endpackage

// File: rtl/can_irq_edge.sv
module can_irq_edge
    import can_irq_pkg::*;
#(
    parameter int         W    = 1,
    parameter edge_mode_e MODE = EDGE_RISE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] evt_o
);
    logic [W-1:0] hist_d, hist_q;

    always_comb begin
        hist_d = sig_i;
    end

    always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= hist_d;
    end

    generate
        if (MODE == EDGE_RISE) begin : g_rise
            assign evt_o = sig_i & ~hist_q;
        end else if (MODE == EDGE_FALL) begin : g_fall
            assign evt_o = ~sig_i & hist_q;
        end else begin : g_any
            assign evt_o = sig_i ^ hist_q;
        end
    endgenerate
endmodule

// File: rtl/can_irq_flags.sv
module can_irq_flags
    import can_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t set_i,
    input  logic     clr_i,
    output src_vec_t flags_o,
    output logic     irq_o
);
    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.flags = set_i;              // set beats clear
        else       st_d.flags = st_q.flags | set_i;
        st_d.irq = |st_d.flags;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign flags_o = st_q.flags;
    assign irq_o   = st_q.irq;

    // R3 / R4: after a clearing read only same-cycle events survive
    p_clear_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (flags_o == $past(set_i)));

    // R11: without a clearing read no flag drops
    p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

    // R5: request line tracks the stored flags
    p_irq_tracks_r5: assert property (@(posedge clk) disable iff (rst)
        irq_o == (flags_o != '0));
endmodule

// File: rtl/can_irq_status.sv
module can_irq_status
    import can_irq_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 8,
    parameter int REG_ADDR = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_rd,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              irq_o,
    input  logic              en_rx,
    input  logic              en_tx,
    input  logic              en_err,
    input  logic              en_ovr,
    input  logic              rx_msg_new,
    input  logic              tx_buf_free,
    input  logic              err_status,
    input  logic              bus_status,
    input  logic              sleep_mode,
    input  logic              rxbuf_both_full,
    input  logic              rx_accept_start
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

    logic       tx_rise;
    logic [1:0] stat_chg;
    logic       wake_fall;
    logic       rd_hit;
    src_vec_t   set_v;
    src_vec_t   flags;

    can_irq_edge #(.W(1), .MODE(EDGE_RISE)) u_tx_edge (
        .clk(clk), .rst(rst), .sig_i(tx_buf_free), .evt_o(tx_rise));

    can_irq_edge #(.W(2), .MODE(EDGE_ANY)) u_stat_edge (
        .clk(clk), .rst(rst), .sig_i({bus_status, err_status}), .evt_o(stat_chg));

    can_irq_edge #(.W(1), .MODE(EDGE_FALL)) u_wake_edge (
        .clk(clk), .rst(rst), .sig_i(sleep_mode), .evt_o(wake_fall));

    always_comb begin
        rd_hit        = cpu_rd && (cpu_addr == HIT_ADDR);
        set_v         = '0;
        set_v[B_RX]   = en_rx  && rx_msg_new;
        set_v[B_TX]   = en_tx  && tx_rise;
        set_v[B_ERR]  = en_err && (|stat_chg);
        set_v[B_OVR]  = en_ovr && rxbuf_both_full && rx_accept_start;
        set_v[B_WAKE] = wake_fall;
    end

    can_irq_flags u_flags (
        .clk(clk), .rst(rst), .set_i(set_v), .clr_i(rd_hit),
        .flags_o(flags), .irq_o(irq_o));

    always_comb begin
        cpu_rdata = '0;
        if (rd_hit) cpu_rdata[NUM_SRC-1:0] = flags;
    end

    // R2: reserved bits never carry data
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
        cpu_rdata[DATA_W-1:NUM_SRC] == '0);

    // R6: receive flag cannot rise without an enabled notification
    p_rx_gate_r6: assert property (@(posedge clk) disable iff (rst)
        !(en_rx && rx_msg_new) |=> !$rose(flags[B_RX]));

    // R7: transmit flag needs an enabled rising edge
    p_tx_gate_r7: assert property (@(posedge clk) disable iff (rst)
        !(en_tx && tx_rise) |=> !$rose(flags[B_TX]));

    // R8: error flag needs an enabled status change
    p_err_gate_r8: assert property (@(posedge clk) disable iff (rst)
        !(en_err && (stat_chg != 2'b00)) |=> !$rose(flags[B_ERR]));

    // R9: overrun flag needs all three conditions
    p_ovr_gate_r9: assert property (@(posedge clk) disable iff (rst)
        !(en_ovr && rxbuf_both_full && rx_accept_start) |=> !$rose(flags[B_OVR]));

    // R10: wake-up flag only after leaving sleep
    p_wake_gate_r10: assert property (@(posedge clk) disable iff (rst)
        !wake_fall |=> !$rose(flags[B_WAKE]));
endmodule

// File: tb/can_irq_status_tb_top.sv
module can_irq_status_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV         = 22;

    typedef struct packed {
        logic       rd;
        logic [4:0] addr;
        logic [3:0] en;     // {ovr, err, tx, rx}
        logic       rxn;
        logic       tx;
        logic       err;
        logic       bus;
        logic       slp;
        logic       full;
        logic       acc;
        logic [4:0] exp;    // {wake, ovr, err, tx, rx} after the edge
    } vec_t;

    localparam vec_t TBL [NV] = '{
        '{1'b0, 5'd0, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00000}, // R5 idle
        '{1'b0, 5'd0, 4'hF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00001}, // R6 rx set
        '{1'b1, 5'd3, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00000}, // R3 read clears
        '{1'b0, 5'd0, 4'hE, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00000}, // R6 disabled
        '{1'b0, 5'd0, 4'hF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00010}, // R7 rise
        '{1'b1, 5'd3, 4'hF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00000}, // R3
        '{1'b1, 5'd3, 4'hF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00000}, // R7 held level
        '{1'b0, 5'd0, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00000}, // R7 fall
        '{1'b0, 5'd0, 4'hF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00100}, // R8 err rise
        '{1'b1, 5'd7, 4'hF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00100}, // R11 other addr
        '{1'b1, 5'd3, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00100}, // R4 set wins
        '{1'b1, 5'd3, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00000}, // R3
        '{1'b0, 5'd0, 4'hB, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'b00000}, // R8 disabled
        '{1'b0, 5'd0, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00100}, // R8 bus fall
        '{1'b0, 5'd0, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'b01100}, // R9 overrun
        '{1'b1, 5'd3, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'b00000}, // R9 no accept
        '{1'b0, 5'd0, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'b00000}, // R9 not full
        '{1'b0, 5'd0, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'b00000}, // R10 enter sleep
        '{1'b0, 5'd0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'b10000}, // R10 wake
        '{1'b1, 5'd3, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00000}, // R2 layout
        '{1'b0, 5'd0, 4'hF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 5'b01111}, // R2 many
        '{1'b1, 5'd3, 4'hF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00000}  // R2
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_rd = 1'b0;
    logic [4:0] cpu_addr = '0;
    logic [7:0] cpu_rdata;
    logic       irq_o;
    logic       en_rx = 1'b0, en_tx = 1'b0, en_err = 1'b0, en_ovr = 1'b0;
    logic       rx_msg_new = 1'b0, tx_buf_free = 1'b0, err_status = 1'b0;
    logic       bus_status = 1'b0, sleep_mode = 1'b0;
    logic       rxbuf_both_full = 1'b0, rx_accept_start = 1'b0;

    int  n_total = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_irq_status dut_i (
        .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
        .cpu_rdata(cpu_rdata), .irq_o(irq_o),
        .en_rx(en_rx), .en_tx(en_tx), .en_err(en_err), .en_ovr(en_ovr),
        .rx_msg_new(rx_msg_new), .tx_buf_free(tx_buf_free),
        .err_status(err_status), .bus_status(bus_status),
        .sleep_mode(sleep_mode), .rxbuf_both_full(rxbuf_both_full),
        .rx_accept_start(rx_accept_start));

    function automatic string row_req(int i);
        case (i)
            0:                 return "R5";
            1, 3:              return "R6";
            2, 5, 11:          return "R3";
            4, 6, 7:           return "R7";
            8, 12, 13:         return "R8";
            9:                 return "R11";
            10:                return "R4";
            14, 15, 16:        return "R9";
            17, 18:            return "R10";
            default:           return "R2";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(vec_t v);
        cpu_rd          = v.rd;
        cpu_addr        = v.addr;
        {en_ovr, en_err, en_tx, en_rx} = v.en;
        rx_msg_new      = v.rxn;
        tx_buf_free     = v.tx;
        err_status      = v.err;
        bus_status      = v.bus;
        sleep_mode      = v.slp;
        rxbuf_both_full = v.full;
        rx_accept_start = v.acc;
    endtask

    task automatic idle_inputs();
        apply('0);
        en_rx = 1'b1; en_tx = 1'b1; en_err = 1'b1; en_ovr = 1'b1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_total++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        logic [4:0] prev;
        logic [7:0] exp_rd;
        repeat (3) @(negedge clk);
        // R1: reset state
        cpu_rd = 1'b1; cpu_addr = 5'd3;
        #1;
        chk("R1", "rdata in reset", cpu_rdata, 8'h00);
        chk("R1", "irq in reset", {7'd0, irq_o}, 8'h00);
        cpu_rd = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "irq after reset", {7'd0, irq_o}, 8'h00);

        prev = '0;
        for (int i = 0; i < NV; i++) begin
            apply(TBL[i]);
            #1;
            if (TBL[i].rd) begin
                exp_rd = (TBL[i].addr == 5'd3) ? {3'b000, prev} : 8'h00;
                chk(row_req(i), $sformatf("row %0d rdata", i), cpu_rdata, exp_rd);
            end
            @(negedge clk);
            chk(row_req(i), $sformatf("row %0d irq", i), {7'd0, irq_o},
                {7'd0, |TBL[i].exp});
            prev = TBL[i].exp;
        end

        // R1: reset mid-run clears a pending flag
        idle_inputs();
        rx_msg_new = 1'b1;
        @(negedge clk);
        rx_msg_new = 1'b0;
        chk("R1", "irq before reset", {7'd0, irq_o}, 8'h01);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "irq after mid reset", {7'd0, irq_o}, 8'h00);
        cpu_rd = 1'b1; cpu_addr = 5'd3;
        #1;
        chk("R1", "rdata after mid reset", cpu_rdata, 8'h00);
        @(negedge clk);
        cpu_rd = 1'b0;

        // R11: flag survives idle cycles, R2 read returns it then clears
        sleep_mode = 1'b1;
        @(negedge clk);
        sleep_mode = 1'b0;
        repeat (4) @(negedge clk);
        chk("R11", "irq held", {7'd0, irq_o}, 8'h01);
        cpu_rd = 1'b1; cpu_addr = 5'd3;
        #1;
        chk("R11", "wake flag held", cpu_rdata, 8'h10);
        @(negedge clk);
        cpu_rd = 1'b0;
        chk("R3", "irq after read", {7'd0, irq_o}, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule